// File: doc/BRIEF.md
# Synchronous Dual-Port RAM Core

This block is a true dual-port synchronous static RAM whose two ports, A and B, each have their own clock and can read or write any word. Every address, data and control input is registered on the rising edge of its port's clock. The default is 256 words of 9 bits. The `ADDR_W` parameter scales the depth up to 32K words (`ADDR_W` = 15).

Each port forms its access address from a burst counter. The counter can be cleared, loaded from the external address, advanced by one, or held. Each port has two chip enables: one active low and one active high. A write select is active low, and an output enable is active low and acts asynchronously.

A shared mode input picks the read latency:
- Flow-through mode gives data one cycle after the address edge.
- Pipelined mode gives data two cycles after the address edge.

A valid flag on each port takes the place of a tri-state data bus. While the flag is low, the data output reads zero.

The storage is built as two banks, one written by each port. A word's value is the XOR of its two bank entries, so each bank has a single writer clocked by its own port.

Top module: `dual_sync_ram`

## Requirements
- R1: On a port's rising edge with the port selected and `wr_n` low, `wdata` is stored at that cycle's effective address.
- R2: With `pipe_mode` = 0, a selected read cycle (`wr_n` high) drives `rdata` with the word at that cycle's effective address and raises `rvalid` right after the same edge.
- R3: With `pipe_mode` = 1, the word read in one selected cycle appears on `rdata` with `rvalid` high after the following edge, provided that cycle is also a selected read.
- R4: The effective address has four sources, in priority order:
  - `clr_n` low: address 0.
  - otherwise `load_n` low: `addr`.
  - otherwise `step_n` low: counter + 1, wrapping modulo the depth.
  - otherwise: the counter.

  The counter takes the effective address at every edge and resets to 0.
- R5: Repeated selected reads with `load_n`, `step_n` and `clr_n` all high keep `rdata` constant.
- R6: A cycle with `en_n` high or `en` low is deselected. It neither writes nor reads, and `rvalid` is low after its edge.
- R7: In pipelined mode, after a deselected or write cycle, `rvalid` rises only after the second consecutive selected read edge.
- R8: `oe_n` high forces `rvalid` low and `rdata` to zero at once, without waiting for a clock edge. Lowering `oe_n` again restores the registered output.
- R9: After the edge of a write cycle, that port's `rvalid` is low in both modes.
- R10: When both ports write the same effective address at the same edge, port A's data is stored.
- R11: A read at the same edge as the other port's write to that address returns the previous contents.
- R12: While `rst_n` is low, both `rvalid` outputs are low, the counters are zero and every word is cleared to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst_n | input | 1 | Asynchronous active-low reset |
| pipe_mode | input | 1 | 0 = flow-through reads, 1 = pipelined reads |
| a_clk | input | 1 | Port A clock |
| a_en_n | input | 1 | Port A enable, active low |
| a_en | input | 1 | Port A enable, active high |
| a_wr_n | input | 1 | Port A write select, low = write |
| a_load_n | input | 1 | Port A load external address, active low |
| a_step_n | input | 1 | Port A advance counter, active low |
| a_clr_n | input | 1 | Port A clear counter, active low |
| a_oe_n | input | 1 | Port A asynchronous output enable, active low |
| a_addr | input | ADDR_W | Port A external address |
| a_wdata | input | DATA_W | Port A write data |
| a_rdata | output | DATA_W | Port A read data (zero when not valid) |
| a_rvalid | output | 1 | Port A read data driven |
| b_clk | input | 1 | Port B clock |
| b_en_n | input | 1 | Port B enable, active low |
| b_en | input | 1 | Port B enable, active high |
| b_wr_n | input | 1 | Port B write select, low = write |
| b_load_n | input | 1 | Port B load external address, active low |
| b_step_n | input | 1 | Port B advance counter, active low |
| b_clr_n | input | 1 | Port B clear counter, active low |
| b_oe_n | input | 1 | Port B asynchronous output enable, active low |
| b_addr | input | ADDR_W | Port B external address |
| b_wdata | input | DATA_W | Port B write data |
| b_rdata | output | DATA_W | Port B read data (zero when not valid) |
| b_rvalid | output | 1 | Port B read data driven |

## Verification
The check runs on a 16-word configuration of the block:
- **Sweeps.** Every word is written with a distinct arithmetic pattern and then read back in reverse address order. This separates address decoding faults from data faults.
- **Counter.** A burst crosses the top address, which exposes errors in the wrap and in the priority between clear, load and step. Held reads and toggling the output enable in mid-cycle separate registered hold behaviour from combinational gating.
- **Pipelined mode.** A back-to-back read stream started after a deselected cycle distinguishes the one-cycle and two-cycle latencies. It also checks the wake-up rule.
- **Port interaction.** Same-address writes on both ports test the write priority, and a read during the other port's write tests read-before-write.

// File: rtl/dpr_pkg.sv
`timescale 1ns/1ps
package dpr_pkg;

    typedef enum logic [1:0] {
        SRC_HOLD  = 2'd0,
        SRC_STEP  = 2'd1,
        SRC_LOAD  = 2'd2,
        SRC_CLEAR = 2'd3
    } addr_src_e;

    // Clear beats load, load beats step.
    function automatic addr_src_e pick_src(input logic clr_n, input logic load_n,
                                           input logic step_n);
        if (!clr_n)  return SRC_CLEAR;
        if (!load_n) return SRC_LOAD;
        if (!step_n) return SRC_STEP;
        return SRC_HOLD;
    endfunction

endpackage

// File: rtl/dpr_addr_ctr.sv
`timescale 1ns/1ps
module dpr_addr_ctr #(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr_n,
    input  logic              load_n,
    input  logic              step_n,
    input  logic [ADDR_W-1:0] ext_addr,
    output logic [ADDR_W-1:0] eff_addr
);
    import dpr_pkg::*;

    typedef struct packed {
        logic [ADDR_W-1:0] cnt;
    } ctr_st_t;

    ctr_st_t   st_d, st_q;
    addr_src_e src_d;

    always_comb begin
        src_d = pick_src(clr_n, load_n, step_n);
        st_d  = st_q;
        unique case (src_d)
            SRC_CLEAR: st_d.cnt = '0;
            SRC_LOAD:  st_d.cnt = ext_addr;
            SRC_STEP:  st_d.cnt = st_q.cnt + 1'b1;
            default:   st_d.cnt = st_q.cnt;
        endcase
        eff_addr = st_d.cnt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R4
    load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_n && !load_n) |=> (st_q.cnt == $past(ext_addr)));
    // R4
    clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !clr_n |=> (st_q.cnt == '0));
    // R5
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_n && load_n && step_n) |=> $stable(st_q.cnt));

endmodule

// File: rtl/dpr_rd_pipe.sv
`timescale 1ns/1ps
module dpr_rd_pipe #(
    parameter int DATA_W = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel,
    input  logic              wr,
    input  logic              pipe_mode,
    input  logic              oe_n,
    input  logic [DATA_W-1:0] mem_word,
    output logic [DATA_W-1:0] rdata,
    output logic              rvalid
);
    typedef struct packed {
        logic              v1;
        logic [DATA_W-1:0] d1;
        logic              v2;
        logic [DATA_W-1:0] d2;
    } pipe_st_t;

    pipe_st_t st_d, st_q;
    logic     rd_cyc;
    logic     stage_v;

    always_comb begin
        rd_cyc  = sel & ~wr;
        st_d    = st_q;
        st_d.v1 = rd_cyc;
        st_d.d1 = rd_cyc ? mem_word : st_q.d1;
        st_d.v2 = rd_cyc & st_q.v1;
        st_d.d2 = st_q.d1;
        stage_v = pipe_mode ? st_q.v2 : st_q.v1;
        rvalid  = stage_v & ~oe_n;
        rdata   = rvalid ? (pipe_mode ? st_q.d2 : st_q.d1) : '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R6 R9
    quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!sel || wr) |=> (!st_q.v1 && !st_q.v2));
    // R7
    wake_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.v2 |-> $past(st_q.v1));
    // R2
    ft_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sel && !wr) |=> (st_q.d1 == $past(mem_word)));

endmodule

// File: rtl/dpr_xor_store.sv
`timescale 1ns/1ps
module dpr_xor_store #(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 9
) (
    input  logic              rst_n,
    input  logic              a_clk,
    input  logic              a_we,
    input  logic [ADDR_W-1:0] a_addr,
    input  logic [DATA_W-1:0] a_wdata,
    output logic [DATA_W-1:0] a_word,
    input  logic              b_clk,
    input  logic              b_we,
    input  logic [ADDR_W-1:0] b_addr,
    input  logic [DATA_W-1:0] b_wdata,
    output logic [DATA_W-1:0] b_word
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] bank_a_q [DEPTH];
    logic [DATA_W-1:0] bank_b_q [DEPTH];
    logic              b_we_d;

    assign a_word = bank_a_q[a_addr] ^ bank_b_q[a_addr];
    assign b_word = bank_a_q[b_addr] ^ bank_b_q[b_addr];
    // Port A wins a same-address write.
    assign b_we_d = b_we & ~(a_we & (a_addr == b_addr));

    always_ff @(posedge a_clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) bank_a_q[i] <= '0;
        end else if (a_we) begin
            bank_a_q[a_addr] <= a_wdata ^ bank_b_q[a_addr];
        end
    end

    always_ff @(posedge b_clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) bank_b_q[i] <= '0;
        end else if (b_we_d) begin
            bank_b_q[b_addr] <= b_wdata ^ bank_a_q[b_addr];
        end
    end

    // R1 R10
    a_wins_chk: assert property (@(posedge a_clk) disable iff (!rst_n)
        a_we |=> ((bank_a_q[$past(a_addr)] ^ bank_b_q[$past(a_addr)]) == $past(a_wdata)));

endmodule

// File: rtl/dual_sync_ram.sv
`timescale 1ns/1ps
module dual_sync_ram #(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 9
) (
    input  logic              rst_n,
    input  logic              pipe_mode,
    input  logic              a_clk,
    input  logic              a_en_n,
    input  logic              a_en,
    input  logic              a_wr_n,
    input  logic              a_load_n,
    input  logic              a_step_n,
    input  logic              a_clr_n,
    input  logic              a_oe_n,
    input  logic [ADDR_W-1:0] a_addr,
    input  logic [DATA_W-1:0] a_wdata,
    output logic [DATA_W-1:0] a_rdata,
    output logic              a_rvalid,
    input  logic              b_clk,
    input  logic              b_en_n,
    input  logic              b_en,
    input  logic              b_wr_n,
    input  logic              b_load_n,
    input  logic              b_step_n,
    input  logic              b_clr_n,
    input  logic              b_oe_n,
    input  logic [ADDR_W-1:0] b_addr,
    input  logic [DATA_W-1:0] b_wdata,
    output logic [DATA_W-1:0] b_rdata,
    output logic              b_rvalid
);
    localparam int NPORT = 2;

    logic [NPORT-1:0]             clk_v, en_n_v, en_v, wr_n_v, load_n_v, step_n_v, clr_n_v, oe_n_v;
    logic [NPORT-1:0]             sel_v, wr_v, we_v, rvalid_v;
    logic [NPORT-1:0][ADDR_W-1:0] addr_v, eff_v;
    logic [NPORT-1:0][DATA_W-1:0] word_v, rdata_v;

    assign clk_v    = {b_clk,    a_clk};
    assign en_n_v   = {b_en_n,   a_en_n};
    assign en_v     = {b_en,     a_en};
    assign wr_n_v   = {b_wr_n,   a_wr_n};
    assign load_n_v = {b_load_n, a_load_n};
    assign step_n_v = {b_step_n, a_step_n};
    assign clr_n_v  = {b_clr_n,  a_clr_n};
    assign oe_n_v   = {b_oe_n,   a_oe_n};
    assign addr_v   = {b_addr,   a_addr};

    for (genvar p = 0; p < NPORT; p++) begin : g_port
        assign sel_v[p] = ~en_n_v[p] & en_v[p];
        assign wr_v[p]  = ~wr_n_v[p];
        assign we_v[p]  = sel_v[p] & wr_v[p];

        dpr_addr_ctr #(.ADDR_W(ADDR_W)) u_ctr (
            .clk      (clk_v[p]),
            .rst_n    (rst_n),
            .clr_n    (clr_n_v[p]),
            .load_n   (load_n_v[p]),
            .step_n   (step_n_v[p]),
            .ext_addr (addr_v[p]),
            .eff_addr (eff_v[p])
        );

        dpr_rd_pipe #(.DATA_W(DATA_W)) u_pipe (
            .clk       (clk_v[p]),
            .rst_n     (rst_n),
            .sel       (sel_v[p]),
            .wr        (wr_v[p]),
            .pipe_mode (pipe_mode),
            .oe_n      (oe_n_v[p]),
            .mem_word  (word_v[p]),
            .rdata     (rdata_v[p]),
            .rvalid    (rvalid_v[p])
        );
    end

    dpr_xor_store #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_store (
        .rst_n   (rst_n),
        .a_clk   (a_clk),
        .a_we    (we_v[0]),
        .a_addr  (eff_v[0]),
        .a_wdata (a_wdata),
        .a_word  (word_v[0]),
        .b_clk   (b_clk),
        .b_we    (we_v[1]),
        .b_addr  (eff_v[1]),
        .b_wdata (b_wdata),
        .b_word  (word_v[1])
    );

    assign a_rdata  = rdata_v[0];
    assign a_rvalid = rvalid_v[0];
    assign b_rdata  = rdata_v[1];
    assign b_rvalid = rvalid_v[1];

endmodule

// File: tb/sim_dual_sync_ram.sv
`timescale 1ns/1ps
module sim_dual_sync_ram;
    localparam int AW = 4;
    localparam int DW = 9;
    localparam int N  = 1 << AW;

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic rst_n, pipe_mode;
    logic a_en_n, a_en, a_wr_n, a_load_n, a_step_n, a_clr_n, a_oe_n;
    logic b_en_n, b_en, b_wr_n, b_load_n, b_step_n, b_clr_n, b_oe_n;
    logic [AW-1:0] a_addr, b_addr;
    logic [DW-1:0] a_wdata, b_wdata, a_rdata, b_rdata;
    logic a_rvalid, b_rvalid;

    int total = 0;
    int bad   = 0;
    int expm [N];
    bit ended = 0;

    dual_sync_ram #(.ADDR_W(AW), .DATA_W(DW)) u0 (
        .rst_n(rst_n), .pipe_mode(pipe_mode),
        .a_clk(clk), .a_en_n(a_en_n), .a_en(a_en), .a_wr_n(a_wr_n), .a_load_n(a_load_n),
        .a_step_n(a_step_n), .a_clr_n(a_clr_n), .a_oe_n(a_oe_n), .a_addr(a_addr),
        .a_wdata(a_wdata), .a_rdata(a_rdata), .a_rvalid(a_rvalid),
        .b_clk(clk), .b_en_n(b_en_n), .b_en(b_en), .b_wr_n(b_wr_n), .b_load_n(b_load_n),
        .b_step_n(b_step_n), .b_clr_n(b_clr_n), .b_oe_n(b_oe_n), .b_addr(b_addr),
        .b_wdata(b_wdata), .b_rdata(b_rdata), .b_rvalid(b_rvalid)
    );

    function automatic int pat(input int i);
        return (i * 37 + 5) % 512;
    endfunction

    task automatic chk(input string req, input int act, input int exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%0h exp=%0h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic a_set(input logic en_n, input logic en, input logic wr_n, input logic load_n,
                         input logic step_n, input logic clr_n, input int ad, input int wd);
        a_en_n = en_n; a_en = en; a_wr_n = wr_n; a_load_n = load_n;
        a_step_n = step_n; a_clr_n = clr_n; a_addr = AW'(ad); a_wdata = DW'(wd);
    endtask

    task automatic b_set(input logic en_n, input logic en, input logic wr_n, input logic load_n,
                         input logic step_n, input logic clr_n, input int ad, input int wd);
        b_en_n = en_n; b_en = en; b_wr_n = wr_n; b_load_n = load_n;
        b_step_n = step_n; b_clr_n = clr_n; b_addr = AW'(ad); b_wdata = DW'(wd);
    endtask

    task automatic idle_both();
        a_set(1, 1, 1, 1, 1, 1, 0, 0);
        b_set(1, 1, 1, 1, 1, 1, 0, 0);
    endtask

    task automatic finish_run();
        if (!ended) begin
            ended = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    initial begin
        #1000000;
        total++;
        bad++;
        $display("FAIL watchdog act=timeout exp=done");
        finish_run();
    end

    initial begin
        rst_n = 0; pipe_mode = 0; a_oe_n = 0; b_oe_n = 0;
        idle_both();
        for (int i = 0; i < N; i++) expm[i] = 0;
        tick(); tick();
        chk("R12 a_rvalid in reset", a_rvalid, 0);
        chk("R12 b_rvalid in reset", b_rvalid, 0);
        rst_n = 1;
        tick();

        // R12 memory cleared; counter at zero
        b_set(0, 1, 1, 0, 1, 1, 7, 0); tick();
        chk("R12 cleared word", b_rdata, 0);
        a_set(0, 1, 1, 1, 1, 1, 0, 0); tick();
        chk("R12 counter zero read", a_rdata, 0);
        idle_both();

        // R1 write sweep on A, R9 no drive after write
        for (int i = 0; i < N; i++) begin
            a_set(0, 1, 0, 0, 1, 1, i, pat(i));
            expm[i] = pat(i);
            tick();
            chk("R9 a_rvalid after write", a_rvalid, 0);
        end
        idle_both();

        // R2 flow-through reverse sweep on B, forward on A
        for (int i = N - 1; i >= 0; i--) begin
            b_set(0, 1, 1, 0, 1, 1, i, 0); tick();
            chk("R2 b_rvalid", b_rvalid, 1);
            chk("R1 R2 b_rdata", b_rdata, expm[i]);
        end
        for (int i = 0; i < N; i++) begin
            a_set(0, 1, 1, 0, 1, 1, i, 0); tick();
            chk("R2 a_rdata", a_rdata, expm[i]);
        end
        idle_both();

        // R4 counter burst with wrap
        b_set(0, 1, 1, 0, 1, 1, N - 2, 0); tick();
        chk("R4 load", b_rdata, expm[N-2]);
        for (int k = 1; k <= 4; k++) begin
            b_set(0, 1, 1, 1, 0, 1, 0, 0); tick();
            chk("R4 step wrap", b_rdata, expm[(N - 2 + k) % N]);
        end
        // R5 hold
        for (int k = 0; k < 3; k++) begin
            b_set(0, 1, 1, 1, 1, 1, 9, 0); tick();
            chk("R5 hold", b_rdata, expm[2]);
        end
        // R4 clear beats load
        b_set(0, 1, 1, 0, 0, 0, 9, 0); tick();
        chk("R4 clear priority", b_rdata, expm[0]);
        b_set(0, 1, 1, 0, 0, 1, 9, 0); tick();
        chk("R4 load over step", b_rdata, expm[9]);
        idle_both();

        // R1 R4 write with counter advance on A
        a_set(0, 1, 0, 0, 1, 1, 3, 'h103); expm[3] = 'h103; tick();
        a_set(0, 1, 0, 1, 0, 1, 0, 'h104); expm[4] = 'h104; tick();
        a_set(0, 1, 0, 1, 0, 1, 0, 'h105); expm[5] = 'h105; tick();
        idle_both();
        b_set(0, 1, 1, 0, 1, 1, 3, 0); tick();
        chk("R1 counter write 3", b_rdata, expm[3]);
        b_set(0, 1, 1, 1, 0, 1, 0, 0); tick();
        chk("R1 counter write 4", b_rdata, expm[4]);
        b_set(0, 1, 1, 1, 0, 1, 0, 0); tick();
        chk("R1 counter write 5", b_rdata, expm[5]);

        // R8 asynchronous output enable, within one cycle
        b_oe_n = 1; #1;
        chk("R8 oe off rvalid", b_rvalid, 0);
        chk("R8 oe off rdata", b_rdata, 0);
        b_oe_n = 0; #1;
        chk("R8 oe on rvalid", b_rvalid, 1);
        chk("R8 oe on rdata", b_rdata, expm[5]);

        // R6 deselection both ways
        b_set(1, 1, 1, 1, 1, 1, 0, 0); tick();
        chk("R6 en_n high", b_rvalid, 0);
        b_set(0, 1, 1, 0, 1, 1, 5, 0); tick();
        b_set(0, 0, 1, 0, 1, 1, 5, 0); tick();
        chk("R6 en low", b_rvalid, 0);
        b_set(1, 1, 1, 1, 1, 1, 0, 0);
        a_set(1, 1, 0, 0, 1, 1, 8, 'h1FF); tick();
        a_set(0, 0, 0, 0, 1, 1, 8, 'h1FE); tick();
        idle_both();
        b_set(0, 1, 1, 0, 1, 1, 8, 0); tick();
        chk("R6 deselected write ignored", b_rdata, expm[8]);
        idle_both(); tick();

        // R3 R7 pipelined stream after deselect
        pipe_mode = 1;
        for (int i = 0; i < N; i++) begin
            b_set(0, 1, 1, 0, 1, 1, i, 0); tick();
            if (i == 0) chk("R7 first edge quiet", b_rvalid, 0);
            else begin
                chk("R3 pipe rvalid", b_rvalid, 1);
                chk("R3 pipe rdata", b_rdata, expm[i-1]);
            end
        end
        b_set(1, 1, 1, 1, 1, 1, 0, 0); tick();
        chk("R6 pipe deselect", b_rvalid, 0);
        b_set(0, 1, 1, 0, 1, 1, 2, 0); tick();
        chk("R7 wake first", b_rvalid, 0);
        b_set(0, 1, 1, 0, 1, 1, 3, 0); tick();
        chk("R7 wake second", b_rvalid, 1);
        chk("R7 wake data", b_rdata, expm[2]);
        b_set(0, 1, 0, 0, 1, 1, 3, 'h0AB); expm[3] = 'h0AB; tick();
        chk("R9 pipe write quiet", b_rvalid, 0);
        b_set(0, 1, 1, 0, 1, 1, 3, 0); tick();
        chk("R7 after write first", b_rvalid, 0);
        b_set(0, 1, 1, 1, 1, 1, 0, 0); tick();
        chk("R3 R5 pipe hold data", b_rdata, expm[3]);
        idle_both(); tick();
        pipe_mode = 0;

        // R10 same-address collision
        a_set(0, 1, 0, 0, 1, 1, 9, 'h1AA);
        b_set(0, 1, 0, 0, 1, 1, 9, 'h055);
        expm[9] = 'h1AA;
        tick();
        idle_both();
        b_set(0, 1, 1, 0, 1, 1, 9, 0); tick();
        chk("R10 port A wins", b_rdata, expm[9]);

        // R11 read during the other port's write
        a_set(0, 1, 0, 0, 1, 1, 6, 'h0F0);
        b_set(0, 1, 1, 0, 1, 1, 6, 0);
        tick();
        chk("R11 old data", b_rdata, expm[6]);
        expm[6] = 'h0F0;
        a_set(1, 1, 1, 1, 1, 1, 0, 0);
        tick();
        chk("R11 new data next", b_rdata, expm[6]);

        finish_run();
    end
endmodule